// File: doc/BRIEF.md
# SCSI Host DMA Channel Controller

This block is the bus-master DMA channel that sits next to a SCSI protocol core. Software loads a start byte count, a start memory address and a start descriptor-list address through a small word-addressed register port. It then writes a command. A start command copies the start values into the working count and working address registers and enables DMA toward the core. After that, each transfer request from the core is turned into one request on a valid/ready memory port. The transfer length is clamped to the remaining count, and the working count and address move by the amount actually moved.

Status flags record completion. They are cleared in one of two ways, selected by bit 24 of a separate bus-control register. With the bit set, software writes ones to clear chosen flags. With the bit clear, reading the status clears the flags. The SCSI core's interrupt line is merged live into the status value that software reads back. An interrupt output follows the done flag when the done-interrupt enable is set. Descriptor-list mode and the burst-flush command are only recorded in the command register; they have no other effect.

Top module: `scsi_dma_chan`

## Requirements
- R1: After reset the command register reads 0, the working count reads 0, the working address reads 0xFFFFFFFF, the working descriptor address reads 0xFFFFFFFD, the status reads 0 (with the core interrupt low), `dma_en` is 0 and `irq` is 0.
- R2: Register word offsets on `reg_addr` are as follows:
  - 0: command
  - 1: start count
  - 2: start address
  - 3: working count
  - 4: working address
  - 5: status
  - 6: start descriptor address
  - 7: working descriptor address
  - 8: bus-control

  Read data appears on `reg_rdata` one cycle after `reg_rd`. Writes to offsets 3, 4 and 7 and to unmapped offsets change nothing. Unmapped offsets read 0.
- R3: The command register keeps the whole written word. A command whose bits [1:0] are 3 (start) copies the start count, address and descriptor address into their working registers. It also clears all status flags and sets `dma_en`.
- R4: Command code 0 (idle) clears `dma_en`. Code 2 (abort) pulses `core_cancel` high for exactly one cycle. Code 1 (blast) changes nothing except the stored command.
- R5: With bus-control bit 24 set, a status write clears only those of error (bit 1), abort (bit 2) and done (bit 3) whose data bits are 1. In this mode a status read clears nothing.
- R6: With bus-control bit 24 clear, a status read returns the current flags and then clears error, abort and done. In this mode status writes are ignored.
- R7: Status bit 4 reads as 1 exactly while `core_irq` is high. It is never stored.
- R8: A transfer request whose direction `xfer_to_mem` differs from command bit 7 (1 = device to memory) makes no memory request and changes no register. It is still acknowledged on `xfer_ack`.
- R9: An accepted transfer drives `mem_valid` with `mem_addr` equal to the working address, `mem_len` equal to the smaller of the requested length and the working count, and `mem_to_mem` equal to command bit 7. These values are held until `mem_ready`. On the handshake the working count falls by `mem_len`, the working address rises by it, and done (bit 3) is set if the count reaches 0.
- R10: A `core_done` pulse forces the working count to 0 and sets done.
- R11: `irq` is high one cycle after status done and command bit 6 (done-interrupt enable) are both 1, and low one cycle after either is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| core_irq | input | 1 | Interrupt flag of the SCSI core |
| core_done | input | 1 | Command completion pulse from the SCSI core |
| xfer_req | input | 1 | Transfer request pulse from the SCSI core |
| xfer_to_mem | input | 1 | Request direction, 1 = device to memory |
| xfer_len | input | 16 | Requested length in bytes |
| xfer_ack | output | 1 | One-cycle pulse when a request is finished or dropped |
| dma_en | output | 1 | DMA enabled toward the SCSI core |
| core_cancel | output | 1 | One-cycle request to cancel the current SCSI transfer |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_addr | output | 32 | Memory request address |
| mem_len | output | 16 | Memory request length |
| mem_to_mem | output | 1 | Memory request direction, 1 = write to memory |
| irq | output | 1 | Done interrupt |

## Verification
The hardest case to reach is a transfer that asks for more than the remaining count. Here the clamp, the count reaching exactly zero and the done flag all coincide on one handshake edge. The bench reaches it with two transfers: the first leaves a partial count, and the second requests more than that remainder. The bench then reads status in both clear modes to show that done is retained or consumed as each mode requires. A dropped request is checked in the same way. The bench issues a request with the wrong direction right after a clamped transfer and reads back the count and address to show that they did not move.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  localparam int OFF_CMD   = 0;
  localparam int OFF_SCNT  = 1;
  localparam int OFF_SADR  = 2;
  localparam int OFF_WCNT  = 3;
  localparam int OFF_WADR  = 4;
  localparam int OFF_STAT  = 5;
  localparam int OFF_SLST  = 6;
  localparam int OFF_WLST  = 7;
  localparam int OFF_BCTL  = 8;

  localparam int CMD_DIR_BIT   = 7;
  localparam int CMD_DONEIE_BIT = 6;
  localparam int ST_DONE_BIT   = 3;
  localparam int ST_CORE_BIT   = 4;
  localparam int BCTL_W1C_BIT  = 24;

  localparam logic [7:0] ST_CLEARABLE = 8'h0E;
  localparam logic [7:0] ST_STORED    = 8'h2F;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_BLAST = 2'd1,
    OP_ABORT = 2'd2,
    OP_START = 2'd3
  } op_e;

  typedef enum logic {
    ENG_IDLE = 1'b0,
    ENG_BUSY = 1'b1
  } eng_state_e;
endpackage

// File: rtl/sdma_engine.sv
module sdma_engine #(
  parameter int DW    = 32,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xfer_req,
  input  logic             xfer_to_mem,
  input  logic [LEN_W-1:0] xfer_len,
  input  logic             cmd_dir,
  input  logic [DW-1:0]    wcnt,
  input  logic [DW-1:0]    wadr,
  output logic             xfer_ack,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic [DW-1:0]    mem_addr,
  output logic [LEN_W-1:0] mem_len,
  output logic             mem_to_mem,
  output logic             upd,
  output logic [LEN_W-1:0] upd_len
);
  import sdma_pkg::*;

  localparam int PAD_W = DW - LEN_W;

  eng_state_e       state;
  logic             dir_ok;
  logic [LEN_W-1:0] clamp_len;
  logic             cnt_small;

  assign dir_ok    = (xfer_to_mem == cmd_dir);
  assign cnt_small = (wcnt < {{PAD_W{1'b0}}, xfer_len});
  assign clamp_len = cnt_small ? wcnt[LEN_W-1:0] : xfer_len;
  assign upd       = mem_valid && mem_ready;
  assign upd_len   = mem_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ENG_IDLE;
      mem_valid  <= 1'b0;
      mem_addr   <= '0;
      mem_len    <= '0;
      mem_to_mem <= 1'b0;
      xfer_ack   <= 1'b0;
    end else begin
      xfer_ack <= 1'b0;
      case (state)
        ENG_IDLE: begin
          if (xfer_req) begin
            if (!dir_ok) begin
              xfer_ack <= 1'b1;
            end else begin
              state      <= ENG_BUSY;
              mem_valid  <= 1'b1;
              mem_addr   <= wadr;
              mem_len    <= clamp_len;
              mem_to_mem <= cmd_dir;
            end
          end
        end
        ENG_BUSY: begin
          if (mem_ready) begin
            state     <= ENG_IDLE;
            mem_valid <= 1'b0;
            xfer_ack  <= 1'b1;
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_len) && $stable(mem_to_mem)));

  p_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ENG_IDLE && xfer_req && !dir_ok) |=> (!mem_valid && xfer_ack));

  p_clamp_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ENG_IDLE && xfer_req && dir_ok) |=> ({{PAD_W{1'b0}}, mem_len} <= $past(wcnt)));
endmodule

// File: rtl/sdma_regs.sv
module sdma_regs #(
  parameter int DW    = 32,
  parameter int AW    = 4,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             core_irq,
  input  logic             core_done,
  input  logic             upd,
  input  logic [LEN_W-1:0] upd_len,
  output logic [DW-1:0]    wcnt,
  output logic [DW-1:0]    wadr,
  output logic             cmd_dir,
  output logic             dma_en,
  output logic             core_cancel,
  output logic             irq
);
  import sdma_pkg::*;

  localparam int PAD_W = DW - LEN_W;
  localparam logic [DW-1:0] WADR_RST = {DW{1'b1}};
  localparam logic [DW-1:0] WLST_RST = {{(DW-2){1'b1}}, 2'b01};

  logic [DW-1:0] cmd_q, scnt_q, sadr_q, slst_q, wlst_q, bctl_q;
  logic [7:0]    stat_q, stat_n;
  logic [DW-1:0] upd_ext;
  logic          wr_cmd, is_start, w1c_mode, wr_stat, rd_stat, zero_after;
  logic [DW-1:0] rd_mux;

  assign upd_ext    = {{PAD_W{1'b0}}, upd_len};
  assign wr_cmd     = reg_wr && (reg_addr == AW'(OFF_CMD));
  assign is_start   = wr_cmd && (reg_wdata[1:0] == OP_START);
  assign w1c_mode   = bctl_q[BCTL_W1C_BIT];
  assign wr_stat    = reg_wr && (reg_addr == AW'(OFF_STAT));
  assign rd_stat    = reg_rd && (reg_addr == AW'(OFF_STAT));
  assign zero_after = (upd_ext >= wcnt);
  assign cmd_dir    = cmd_q[CMD_DIR_BIT];

  // status next value: start clears, then software clears, then hardware sets
  always_comb begin
    stat_n = stat_q;
    if (is_start) stat_n = '0;
    if (wr_stat && w1c_mode) stat_n = stat_n & ~(reg_wdata[7:0] & ST_CLEARABLE);
    if (rd_stat && !w1c_mode) stat_n = stat_n & ~ST_CLEARABLE;
    if (upd && zero_after) stat_n[ST_DONE_BIT] = 1'b1;
    if (core_done) stat_n[ST_DONE_BIT] = 1'b1;
    stat_n = stat_n & ST_STORED;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q       <= '0;
      scnt_q      <= '0;
      sadr_q      <= '0;
      slst_q      <= '0;
      bctl_q      <= '0;
      wcnt        <= '0;
      wadr        <= WADR_RST;
      wlst_q      <= WLST_RST;
      stat_q      <= '0;
      dma_en      <= 1'b0;
      core_cancel <= 1'b0;
    end else begin
      core_cancel <= 1'b0;
      stat_q      <= stat_n;
      if (reg_wr) begin
        case (reg_addr)
          AW'(OFF_CMD): begin
            cmd_q <= reg_wdata;
            case (op_e'(reg_wdata[1:0]))
              OP_IDLE:  dma_en <= 1'b0;
              OP_ABORT: core_cancel <= 1'b1;
              OP_START: begin
                wcnt   <= scnt_q;
                wadr   <= sadr_q;
                wlst_q <= slst_q;
                dma_en <= 1'b1;
              end
              default: ;
            endcase
          end
          AW'(OFF_SCNT): scnt_q <= reg_wdata;
          AW'(OFF_SADR): sadr_q <= reg_wdata;
          AW'(OFF_SLST): slst_q <= reg_wdata;
          AW'(OFF_BCTL): bctl_q <= reg_wdata;
          default: ;
        endcase
      end
      if (upd) begin
        wcnt <= zero_after ? '0 : wcnt - upd_ext;
        wadr <= wadr + upd_ext;
      end
      if (core_done) wcnt <= '0;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      AW'(OFF_CMD):  rd_mux = cmd_q;
      AW'(OFF_SCNT): rd_mux = scnt_q;
      AW'(OFF_SADR): rd_mux = sadr_q;
      AW'(OFF_WCNT): rd_mux = wcnt;
      AW'(OFF_WADR): rd_mux = wadr;
      AW'(OFF_STAT): begin
        rd_mux[7:0] = stat_q;
        rd_mux[ST_CORE_BIT] = core_irq;
      end
      AW'(OFF_SLST): rd_mux = slst_q;
      AW'(OFF_WLST): rd_mux = wlst_q;
      AW'(OFF_BCTL): rd_mux = bctl_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (reg_rd) reg_rdata <= rd_mux;
      irq <= stat_q[ST_DONE_BIT] && cmd_q[CMD_DONEIE_BIT];
    end
  end

  p_start_copy_r3: assert property (@(posedge clk) disable iff (rst)
    (is_start && !upd && !core_done) |=> (wcnt == $past(scnt_q) && wadr == $past(sadr_q) && dma_en));

  p_complete_r10: assert property (@(posedge clk) disable iff (rst)
    core_done |=> (wcnt == '0 && stat_q[ST_DONE_BIT]));

  p_advance_r9: assert property (@(posedge clk) disable iff (rst)
    (upd && !core_done && !wr_cmd) |=> (wadr == $past(wadr) + $past(upd_ext)));

  p_irq_on_r11: assert property (@(posedge clk) disable iff (rst)
    (stat_q[ST_DONE_BIT] && cmd_q[CMD_DONEIE_BIT]) |=> irq);

  p_irq_off_r11: assert property (@(posedge clk) disable iff (rst)
    !(stat_q[ST_DONE_BIT] && cmd_q[CMD_DONEIE_BIT]) |=> !irq);

  p_cancel_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    (core_cancel && !(wr_cmd && reg_wdata[1:0] == OP_ABORT)) |=> !core_cancel);
endmodule

// File: rtl/scsi_dma_chan.sv
module scsi_dma_chan #(
  parameter int DW    = 32,
  parameter int AW    = 4,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             core_irq,
  input  logic             core_done,
  input  logic             xfer_req,
  input  logic             xfer_to_mem,
  input  logic [LEN_W-1:0] xfer_len,
  output logic             xfer_ack,
  output logic             dma_en,
  output logic             core_cancel,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic [DW-1:0]    mem_addr,
  output logic [LEN_W-1:0] mem_len,
  output logic             mem_to_mem,
  output logic             irq
);
  logic [DW-1:0]    wcnt, wadr;
  logic             cmd_dir, upd;
  logic [LEN_W-1:0] upd_len;

  sdma_regs #(.DW(DW), .AW(AW), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .core_irq(core_irq), .core_done(core_done),
    .upd(upd), .upd_len(upd_len),
    .wcnt(wcnt), .wadr(wadr), .cmd_dir(cmd_dir),
    .dma_en(dma_en), .core_cancel(core_cancel), .irq(irq)
  );

  sdma_engine #(.DW(DW), .LEN_W(LEN_W)) u_engine (
    .clk(clk), .rst(rst),
    .xfer_req(xfer_req), .xfer_to_mem(xfer_to_mem), .xfer_len(xfer_len),
    .cmd_dir(cmd_dir), .wcnt(wcnt), .wadr(wadr),
    .xfer_ack(xfer_ack),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_len(mem_len), .mem_to_mem(mem_to_mem),
    .upd(upd), .upd_len(upd_len)
  );
endmodule

// File: tb/scsi_dma_chan_bench.sv
`timescale 1ns/1ps
module scsi_dma_chan_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        core_irq = 1'b0, core_done = 1'b0;
  logic        xfer_req = 1'b0, xfer_to_mem = 1'b0;
  logic [15:0] xfer_len = '0;
  logic        xfer_ack, dma_en, core_cancel, mem_valid, mem_to_mem, irq;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr;
  logic [15:0] mem_len;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  scsi_dma_chan u_scsi_dma_chan (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_irq(core_irq),
    .core_done(core_done), .xfer_req(xfer_req), .xfer_to_mem(xfer_to_mem),
    .xfer_len(xfer_len), .xfer_ack(xfer_ack), .dma_en(dma_en),
    .core_cancel(core_cancel), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_len(mem_len), .mem_to_mem(mem_to_mem), .irq(irq)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 4'(a);
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic xfer(input string req, input logic to_mem, input logic [15:0] len,
                      input logic expect_mem, input logic [31:0] exp_addr, input logic [15:0] exp_len);
    @(negedge clk);
    xfer_req = 1'b1; xfer_to_mem = to_mem; xfer_len = len;
    @(negedge clk);
    xfer_req = 1'b0;
    chk(req, "mem_valid", 32'(mem_valid), 32'(expect_mem));
    if (expect_mem && mem_valid) begin
      chk(req, "mem_addr", mem_addr, exp_addr);
      chk(req, "mem_len", 32'(mem_len), 32'(exp_len));
      chk(req, "mem_to_mem", 32'(mem_to_mem), 32'(to_mem));
      @(negedge clk);
      chk(req, "held valid", 32'(mem_valid), 32'h1);
      mem_ready = 1'b1;
      @(negedge clk);
      mem_ready = 1'b0;
      chk(req, "ack after handshake", 32'(xfer_ack), 32'h1);
    end else begin
      chk(req, "ack on drop", 32'(xfer_ack), 32'h1);
    end
  endtask

  task automatic t_reset_r1;
    rd(0, rv); chk("R1", "cmd", rv, 32'h0);
    rd(3, rv); chk("R1", "work count", rv, 32'h0);
    rd(4, rv); chk("R1", "work addr", rv, 32'hFFFF_FFFF);
    rd(7, rv); chk("R1", "work list", rv, 32'hFFFF_FFFD);
    rd(5, rv); chk("R1", "status", rv, 32'h0);
    chk("R1", "dma_en", 32'(dma_en), 32'h0);
    chk("R1", "irq", 32'(irq), 32'h0);
  endtask

  task automatic t_map_r2;
    wr(1, 32'h0000_0100);
    rd(1, rv); chk("R2", "start count readback", rv, 32'h100);
    wr(3, 32'h0000_0005);
    rd(3, rv); chk("R2", "work count write ignored", rv, 32'h0);
    wr(12, 32'hDEAD_BEEF);
    rd(12, rv); chk("R2", "unmapped reads 0", rv, 32'h0);
  endtask

  task automatic t_start_r3;
    wr(2, 32'h0000_1000);
    wr(6, 32'h0000_2000);
    wr(0, 32'h0000_0043);
    rd(0, rv); chk("R3", "cmd kept", rv, 32'h43);
    rd(3, rv); chk("R3", "count copied", rv, 32'h100);
    rd(4, rv); chk("R3", "addr copied", rv, 32'h1000);
    rd(7, rv); chk("R3", "list copied", rv, 32'h2000);
    chk("R3", "dma_en", 32'(dma_en), 32'h1);
  endtask

  task automatic t_xfer_r9;
    xfer("R9", 1'b0, 16'h0040, 1'b1, 32'h1000, 16'h0040);
    rd(3, rv); chk("R9", "count after first", rv, 32'hC0);
    rd(4, rv); chk("R9", "addr after first", rv, 32'h1040);
    rd(5, rv); chk("R9", "no done yet", rv, 32'h0);
    wr(8, 32'h0100_0000);
    xfer("R9", 1'b0, 16'h0200, 1'b1, 32'h1040, 16'h00C0);
    rd(3, rv); chk("R9", "count clamped to zero", rv, 32'h0);
    rd(4, rv); chk("R9", "addr after clamp", rv, 32'h1100);
    rd(5, rv); chk("R9", "done set", rv, 32'h08);
    chk("R11", "irq with done and enable", 32'(irq), 32'h1);
  endtask

  task automatic t_drop_r8;
    xfer("R8", 1'b1, 16'h0010, 1'b0, 32'h0, 16'h0);
    rd(3, rv); chk("R8", "count unchanged", rv, 32'h0);
    rd(4, rv); chk("R8", "addr unchanged", rv, 32'h1100);
  endtask

  task automatic t_w1c_r5;
    wr(5, 32'h0000_0002);
    rd(5, rv); chk("R5", "non-matching clear keeps done", rv, 32'h08);
    rd(5, rv); chk("R5", "read does not clear", rv, 32'h08);
    wr(5, 32'h0000_0008);
    rd(5, rv); chk("R5", "done cleared by write", rv, 32'h0);
    chk("R11", "irq drops", 32'(irq), 32'h0);
  endtask

  task automatic t_complete_r10;
    wr(0, 32'h0000_0003);
    rd(3, rv); chk("R10", "count reloaded", rv, 32'h100);
    @(negedge clk); core_done = 1'b1;
    @(negedge clk); core_done = 1'b0;
    rd(3, rv); chk("R10", "count forced zero", rv, 32'h0);
    rd(5, rv); chk("R10", "done set", rv, 32'h08);
    chk("R11", "no irq without enable", 32'(irq), 32'h0);
  endtask

  task automatic t_cor_r6;
    wr(8, 32'h0000_0000);
    wr(5, 32'h0000_0008);
    rd(5, rv); chk("R6", "write ignored, read returns done", rv, 32'h08);
    rd(5, rv); chk("R6", "cleared after read", rv, 32'h0);
  endtask

  task automatic t_merge_r7;
    core_irq = 1'b1;
    rd(5, rv); chk("R7", "core irq merged", rv, 32'h10);
    core_irq = 1'b0;
    rd(5, rv); chk("R7", "core irq not stored", rv, 32'h0);
  endtask

  task automatic t_ops_r4;
    wr(0, 32'h0000_0002);
    chk("R4", "cancel pulse", 32'(core_cancel), 32'h1);
    @(negedge clk);
    chk("R4", "cancel one cycle", 32'(core_cancel), 32'h0);
    chk("R4", "abort keeps dma_en", 32'(dma_en), 32'h1);
    wr(0, 32'h0000_0001);
    rd(0, rv); chk("R4", "blast recorded", rv, 32'h1);
    chk("R4", "blast keeps dma_en", 32'(dma_en), 32'h1);
    rd(3, rv); chk("R4", "blast keeps count", rv, 32'h0);
    wr(0, 32'h0000_0000);
    chk("R4", "idle clears dma_en", 32'(dma_en), 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_r1();
    t_map_r2();
    t_start_r3();
    t_xfer_r9();
    t_drop_r8();
    t_w1c_r5();
    t_complete_r10();
    t_cor_r6();
    t_merge_r7();
    t_ops_r4();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule